// File: doc/BRIEF.md
# Dual-Accumulator Fractional/Integer MAC

This block is the arithmetic heart of a 16-bit signal-processing core. Each accepted command multiplies two signed 16-bit operands and combines the product with one of two 40-bit accumulators, all within a single clock. A per-command mode bit selects integer arithmetic or fractional arithmetic. In fractional mode the product is aligned one bit to the left, so that Q15 times Q15 gives Q31. Every accumulator keeps eight guard bits above a 32-bit body, so a long run of accumulations can overflow the body without losing the result.

Commands arrive on a valid/ready stream. The block takes one command in every cycle and never applies back-pressure, so `cmd_ready` is always high once reset is released. A command is consumed in every cycle in which `cmd_valid` is high. A command can overwrite the destination with the product, add the product, subtract the product, or load a 16-bit word from the bus. Each command may also request convergent rounding of the value it writes.

Reading is plain control and has no handshake. `rd_sel` picks an accumulator, which appears unchanged on `rd_full` and limited to 16 bits on `rd_data`. Pulsing `rd_en` marks a read that counts as a bus transfer: if the value had to be limited, a sticky flag is set. A synchronous clear wipes both accumulators and the flag.

Top module: `dual_acc_mac`

## Requirements
- R1: After reset, both accumulators read zero, `limit` is 0 and `cmd_ready` is 1.
- R2: An accepted command with `cmd_op`=0 (multiply) and `cmd_frac`=0 writes the sign-extended 32-bit product a*b to the destination accumulator on the next clock edge.
- R3: When `cmd_frac`=1, the product is doubled (shifted left one bit) before it is used.
- R4: `cmd_op`=1 adds the product to the destination and `cmd_op`=2 subtracts it. Both use 40-bit two's-complement arithmetic that wraps at 40 bits, and the 8 guard bits (39:32) take up any carry out of the 32-bit body.
- R5: `cmd_dst` (0 or 1) selects the accumulator that is written. The other accumulator keeps its value.
- R6: `cmd_op`=3 loads `cmd_a` into bits 31:16, sign-extends it through bits 39:32 and clears bits 15:0.
- R7: With `cmd_rnd`=1, the written value is rounded at bit 15. The block adds 0x8000 and clears bits 15:0, except that when bits 15:0 are exactly 0x8000 the result rounds to the even value (bit 16 ends at 0).
- R8: `rd_full` shows the selected accumulator unchanged. `rd_data` shows bits 31:16 when bits 39:31 are all equal. Otherwise `rd_data` is 0x7FFF for a positive value or 0x8000 for a negative value.
- R9: `limit` becomes 1 on the clock edge after a cycle in which `rd_en`=1 and the selected accumulator needs limiting, and it stays 1 until a clear.
- R10: `clr`=1 zeroes both accumulators and `limit` on the next edge, and it takes priority over a command in the same cycle.
- R11: While `cmd_valid`=0, both accumulators hold their values whatever the other command inputs carry.
- R12: `cmd_ready` is constantly 1 after reset. A command is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of both accumulators and the limit flag |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 2 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 load |
| cmd_dst | input | 1 | Destination accumulator |
| cmd_frac | input | 1 | 1 selects fractional product alignment |
| cmd_rnd | input | 1 | 1 requests convergent rounding of the written value |
| cmd_a | input | 16 | Signed operand A, also the load word |
| cmd_b | input | 16 | Signed operand B |
| rd_sel | input | 1 | Accumulator shown on the read outputs |
| rd_en | input | 1 | Read strobe that can set the limit flag |
| rd_data | output | 16 | Limited high word of the selected accumulator |
| rd_full | output | 40 | Unlimited selected accumulator |
| limit | output | 1 | Sticky flag set when a strobed read was limited |

## Verification
The bench aims at the fractional product of 0x8000 by itself. Doubled, that product lands exactly at +2^31, so an unshifted datapath reads 0x4000 here, and a missing limiter returns 0x8000 where 0x7FFF is due. Repeated full-scale accumulations push the guard bits and drive both polarities into limiting; a design that drops the extension byte loses these values, or returns a wrapped high word instead of a limit. Rounding is tried on the two exact ties, where the value either rounds down to even or carries, and on a value just above a tie. A plain add-half design gives a wrong result on the even tie. Clear is issued together with a command to prove its priority, idle cycles carry changing operands, and a randomized stretch of mixed commands runs against an independent arithmetic model.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DATA_W  = 16;
  localparam int GUARD_W = 8;
  localparam int ACC_W   = GUARD_W + 2 * DATA_W;

  typedef enum logic [1:0] {
    OP_MPY  = 2'd0,
    OP_MAC  = 2'd1,
    OP_MSU  = 2'd2,
    OP_LOAD = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic                 frac,
  output logic signed [AW-1:0] prod
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] raw;
  logic signed [AW-1:0] wide;

  assign raw  = a * b;
  assign wide = AW'(raw);
  assign prod = frac ? (wide <<< 1) : wide;
endmodule

// File: rtl/mac_rounder.sv
module mac_rounder #(
  parameter int AW = 40,
  parameter int RB = 16
) (
  input  logic [AW-1:0] din,
  input  logic          en,
  output logic [AW-1:0] dout
);
  localparam logic [AW-1:0] HALF = AW'(1) << (RB - 1);
  localparam logic [RB-1:0] TIE  = RB'(1) << (RB - 1);

  logic [AW-1:0] bumped;
  logic [AW-1:0] rounded;

  always_comb begin
    bumped  = din + HALF;
    rounded = {bumped[AW-1:RB], {RB{1'b0}}};
    if (din[RB-1:0] == TIE) rounded[RB] = 1'b0;
    dout = en ? rounded : din;
  end

  always_comb begin
    if (en) a_r7_low_cleared: assert (dout[RB-1:0] == '0);
  end
endmodule

// File: rtl/mac_limiter.sv
module mac_limiter #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [AW-1:0] acc,
  output logic [DW-1:0] word,
  output logic          ovf
);
  localparam int BODY_W = 2 * DW;
  localparam int TOP_W  = AW - BODY_W + 1;

  logic [TOP_W-1:0] top;
  logic [DW-1:0]    pos_max;
  logic [DW-1:0]    neg_max;

  assign top     = acc[AW-1:BODY_W-1];
  assign pos_max = {1'b0, {(DW-1){1'b1}}};
  assign neg_max = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    ovf  = !((top == '0) || (top == '1));
    word = ovf ? (acc[AW-1] ? neg_max : pos_max) : acc[BODY_W-1:DW];
  end

  always_comb begin
    if (ovf) a_r8_limited_value: assert (word == pos_max || word == neg_max);
  end
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_dst,
  input  logic              cmd_frac,
  input  logic              cmd_rnd,
  input  logic [DATA_W-1:0] cmd_a,
  input  logic [DATA_W-1:0] cmd_b,
  input  logic              rd_sel,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [ACC_W-1:0]  rd_full,
  output logic              limit
);
  localparam int NACC  = 2;
  localparam int DST_W = $clog2(NACC);

  logic [ACC_W-1:0] acc_q [NACC];
  logic signed [ACC_W-1:0] prod;
  logic [ACC_W-1:0] base, sum, load_val, pre_rnd, wr_val;
  logic             rd_ovf;
  mac_op_e          op;

  assign op        = mac_op_e'(cmd_op);
  assign cmd_ready = 1'b1;

  mac_product #(.DW(DATA_W), .AW(ACC_W)) u_prod (
    .a(cmd_a), .b(cmd_b), .frac(cmd_frac), .prod(prod)
  );

  always_comb begin
    base     = (op == OP_MPY) ? '0 : acc_q[cmd_dst];
    sum      = (op == OP_MSU) ? base - prod : base + prod;
    load_val = {{(ACC_W - 2 * DATA_W){cmd_a[DATA_W-1]}}, cmd_a, {DATA_W{1'b0}}};
    pre_rnd  = (op == OP_LOAD) ? load_val : sum;
  end

  mac_rounder #(.AW(ACC_W), .RB(DATA_W)) u_rnd (
    .din(pre_rnd), .en(cmd_rnd), .dout(wr_val)
  );

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_q[i] <= '0;
      else if (cmd_valid && cmd_dst == DST_W'(i)) acc_q[i] <= wr_val;
    end
  end

  assign rd_full = acc_q[rd_sel];

  mac_limiter #(.DW(DATA_W), .AW(ACC_W)) u_lim (
    .acc(rd_full), .word(rd_data), .ovf(rd_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr) limit <= 1'b0;
    else if (rd_en && rd_ovf) limit <= 1'b1;
  end

  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q[0] == '0 && acc_q[1] == '0 && !limit));

  a_r9_limit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (limit && !clr) |=> limit);

  a_r9_limit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ovf && !clr) |=> limit);

  a_r5_other_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cmd_dst == 1'b0) |=> $stable(acc_q[1]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !clr) |=> ($stable(acc_q[0]) && $stable(acc_q[1])));

  a_r7_round_written: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_rnd && !clr) |=> (acc_q[$past(cmd_dst)][DATA_W-1:0] == '0));

  a_r12_ready: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready);
endmodule

// File: tb/dual_acc_mac_bench.sv
module dual_acc_mac_bench;
  localparam int CLK_P = 10;
  localparam longint M40 = (64'sd1 <<< 40) - 1;

  logic clk = 0, rst_n = 0, clr = 0, cmd_valid = 0;
  logic cmd_ready;
  logic [1:0] cmd_op = 0;
  logic cmd_dst = 0, cmd_frac = 0, cmd_rnd = 0;
  logic [15:0] cmd_a = 0, cmd_b = 0;
  logic rd_sel = 0, rd_en = 0;
  logic [15:0] rd_data;
  logic [39:0] rd_full;
  logic limit;

  int n_chk = 0, n_fail = 0;
  longint macc [2];
  bit mlim;
  bit done = 0;

  typedef struct {
    string tag;
    logic [39:0] full;
    logic [15:0] data;
    bit lim;
  } exp_t;
  exp_t q[$];
  event ev_mon;

  always #(CLK_P / 2) clk = ~clk;

  dual_acc_mac u_dual_acc_mac (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_frac(cmd_frac), .cmd_rnd(cmd_rnd),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_sel(rd_sel), .rd_en(rd_en),
    .rd_data(rd_data), .rd_full(rd_full), .limit(limit)
  );

  function automatic longint sx40(longint v);
    longint m = v & M40;
    if (m[39]) m = m - (64'sd1 <<< 40);
    return m;
  endfunction

  function automatic bit needs_lim(longint s);
    return (s > 64'sh7FFFFFFF) || (s < -64'sh80000000);
  endfunction

  function automatic logic [15:0] lim_word(longint s);
    if (s > 64'sh7FFFFFFF) return 16'h7FFF;
    if (s < -64'sh80000000) return 16'h8000;
    return 16'((s >>> 16) & 64'hFFFF);
  endfunction

  function automatic longint model(longint acc, int op, bit frac, bit rnd,
                                   logic [15:0] a, logic [15:0] b);
    longint p, v, lo, hi;
    p = longint'($signed(a)) * longint'($signed(b));
    if (frac) p = p * 2;
    case (op)
      0: v = p;
      1: v = acc + p;
      2: v = acc - p;
      default: v = longint'($signed(a)) * 65536;
    endcase
    v = sx40(v);
    if (rnd) begin
      lo = v & 64'hFFFF;
      hi = v >>> 16;
      if (lo > 64'h8000 || (lo == 64'h8000 && hi[0])) hi = hi + 1;
      v = sx40(hi * 65536);
    end
    return v;
  endfunction

  task automatic do_cmd(int op, bit dst, bit frac, bit rnd, logic [15:0] a, logic [15:0] b,
                        bit valid = 1, bit c = 0);
    @(negedge clk);
    rd_en = 0;
    cmd_op = 2'(op); cmd_dst = dst; cmd_frac = frac; cmd_rnd = rnd;
    cmd_a = a; cmd_b = b; cmd_valid = valid; clr = c;
    @(posedge clk);
    if (c) begin
      macc[0] = 0; macc[1] = 0; mlim = 0;
    end else if (valid) begin
      macc[dst] = model(macc[dst], op, frac, rnd, a, b);
    end
    @(negedge clk);
    cmd_valid = 0; clr = 0;
  endtask

  task automatic check_rd(bit sel, bit en, string tag);
    exp_t e;
    @(negedge clk);
    rd_sel = sel; rd_en = en;
    e.tag = tag; e.full = 40'(macc[sel] & M40);
    e.data = lim_word(macc[sel]); e.lim = mlim;
    q.push_back(e);
    ->ev_mon;
    @(posedge clk);
    if (en && needs_lim(macc[sel])) mlim = 1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(ev_mon);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (rd_full !== e.full || rd_data !== e.data || limit !== e.lim || cmd_ready !== 1'b1) begin
          n_fail++;
          $display("FAIL %s: full=%h data=%h limit=%b ready=%b expected full=%h data=%h limit=%b ready=1",
                   e.tag, rd_full, rd_data, limit, cmd_ready, e.full, e.data, e.lim);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    macc[0] = 0; macc[1] = 0; mlim = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_rd(0, 0, "R1 reset acc0");
    check_rd(1, 0, "R1 reset acc1 and R12 ready");
    do_cmd(0, 0, 0, 0, 16'd3, -16'sd5);
    check_rd(0, 0, "R2 integer multiply");
    do_cmd(0, 1, 1, 0, 16'h4000, 16'h4000);
    check_rd(1, 0, "R3 fractional multiply");
    do_cmd(1, 0, 0, 0, 16'd100, 16'd200);
    check_rd(0, 0, "R4 multiply-add");
    do_cmd(2, 0, 1, 0, 16'h1234, 16'h0F00);
    check_rd(0, 0, "R4 fractional multiply-subtract");
    check_rd(1, 0, "R5 other accumulator kept");
    do_cmd(3, 0, 0, 0, 16'h8000, 16'h5555);
    check_rd(0, 0, "R6 load negative word");
    do_cmd(0, 1, 1, 0, 16'h8000, 16'h8000);
    check_rd(1, 0, "R8 positive limit without strobe");
    check_rd(1, 1, "R8 positive limit strobed");
    check_rd(0, 0, "R9 limit flag set");
    for (int i = 0; i < 4; i++) do_cmd(1, 1, 1, 0, 16'h7FFF, 16'h7FFF);
    check_rd(1, 0, "R4 guard bits absorb growth");
    do_cmd(3, 0, 0, 0, 16'h8000, 16'h0);
    do_cmd(2, 0, 1, 0, 16'h7FFF, 16'h7FFF);
    check_rd(0, 1, "R8 negative limit");
    check_rd(0, 0, "R9 limit stays set");
    do_cmd(0, 0, 0, 1, 16'h0100, 16'h0080);
    check_rd(0, 0, "R7 tie rounds down to even");
    do_cmd(0, 0, 0, 1, 16'h0180, 16'h0100);
    check_rd(0, 0, "R7 tie rounds up to even");
    do_cmd(0, 1, 0, 1, 16'd3, 16'h3001);
    check_rd(1, 0, "R7 above half rounds up");
    do_cmd(1, 0, 1, 0, 16'h7777, 16'h1111, 0);
    do_cmd(3, 1, 0, 0, 16'h2222, 16'h0, 0);
    check_rd(0, 0, "R11 idle acc0 unchanged");
    check_rd(1, 0, "R11 idle acc1 unchanged");
    do_cmd(1, 0, 1, 0, 16'h7FFF, 16'h7FFF, 1, 1);
    check_rd(0, 0, "R10 clear beats command");
    check_rd(1, 0, "R10 clear acc1 and flag");
    for (int i = 0; i < 40; i++) begin
      do_cmd(int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), 16'($urandom), 1'($urandom_range(0, 3) != 0));
      check_rd(1'($urandom), 1'($urandom), "R4 random mix");
    end
    done = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule